// File: doc/BRIEF.md
# Fan Tachometer Interval Timer

This block measures the time between pulses arriving from a fan's tachometer output. A 16-bit down-counter starts at 0xFFFF and steps down once every `DIV+1` system clocks, where `DIV` is an 8-bit divider value. Each rising edge of the tach input captures the current count into a capture register, sets a capture pending flag, reloads the counter to 0xFFFF and restarts the divider. Software turns the captured value into an interval, and from that into fan speed. A fan gives two tach pulses per revolution, so the number of steps per pulse is `f_clk × 60 / ((DIV+1) × rpm × 2)`.

A programmable limit register sets the stall threshold. If the counter steps down onto the limit value before any capture arrives, a timeout pending flag is set. Six pending flags feed one interrupt line through a per-bit mask. Software clears flags by writing ones to an acknowledge register. All registers sit on a simple 16-bit register port that takes byte-lane enables, so software can use either byte or halfword accesses.

Top module: `fan_tach_timer`

## Requirements
- R1: After a synchronous reset, COUNT and CAPT read 0xFFFF. LIMIT, DIV, CTRL, PEND and MASK read 0, and `irq_o` is low.
- R2: Writes honour byte lanes. `bus_be[0]` writes bits 7:0 and `bus_be[1]` writes bits 15:8. A lane that is not enabled keeps its old contents. The offsets are COUNT 0x0, CAPT 0x2, LIMIT 0x4, DIV 0x6, CTRL 0x8, PEND 0xA (read only), ACK 0xC (write only, reads 0) and MASK 0xE. Read data appears on `bus_rdata` on the clock after `bus_rd`.
- R3: While running, the counter decrements once every DIV+1 clocks. For two tach rising edges N clocks apart, the second capture holds 0xFFFF − floor((N−1)/(DIV+1)).
- R4: A synchronised tach rising edge while running copies COUNT into CAPT, sets PEND bit 0, reloads COUNT to 0xFFFF and restarts the divider phase.
- R5: When a step takes COUNT to a value equal to LIMIT, PEND bit 4 is set.
- R6: CTRL bit 0 is the run bit. While it is 0, COUNT holds its value and tach edges neither capture nor set flags.
- R7: Writing ones to ACK (low lane) clears those PEND bits and leaves the other bits unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R8: `irq_o` is a register. It is high one clock after any PEND bit is set together with its MASK bit, and low one clock after no such pair exists.
- R9: COUNT stops at 0. It never wraps past 0 to 0xFFFF except through a capture reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_be | input | 2 | Byte-lane write enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tach_in | input | 1 | Asynchronous tachometer pulse input |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench runs the capture path over a range of divider values and pulse spacings. These include spacings shorter than one divider period, which must capture 0xFFFF unchanged, and spacings that end exactly on a divider boundary, which separate a floor error from an off-by-one in the divider restart. A stalled fan with no tach edges exercises the timeout flag. The same stall then drives the mask and acknowledge paths, which shows that the interrupt is gated per bit and that clearing one flag leaves the others alone. Separate cases run the counter down to zero to show it stops there, and pulse the tach input while stopped to show that nothing is captured.

// File: rtl/ftt_pkg.sv
package ftt_pkg;
  localparam int AW = 4;

  localparam logic [AW-1:0] OFS_COUNT = 4'h0;
  localparam logic [AW-1:0] OFS_CAPT  = 4'h2;
  localparam logic [AW-1:0] OFS_LIMIT = 4'h4;
  localparam logic [AW-1:0] OFS_DIV   = 4'h6;
  localparam logic [AW-1:0] OFS_CTRL  = 4'h8;
  localparam logic [AW-1:0] OFS_PEND  = 4'hA;
  localparam logic [AW-1:0] OFS_ACK   = 4'hC;
  localparam logic [AW-1:0] OFS_MASK  = 4'hE;

  localparam int PEND_CAPT_BIT = 0;
  localparam int PEND_TMO_BIT  = 4;
endpackage

// File: rtl/ftt_edge_sync.sv
module ftt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  // sh[LAST:0] is the synchroniser chain, sh[STAGES] the previous sample
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise_o = sh[LAST] & ~sh[STAGES];
endmodule

// File: rtl/ftt_prescaler.sv
module ftt_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] div,
  output logic          tick_o
);
  logic [PW-1:0] pcnt;

  assign tick_o = run && (pcnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run || restart || tick_o) pcnt <= '0;
    else                                  pcnt <= pcnt + 1'b1;
  end

  // R3
  tick_restart_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (pcnt == '0));
endmodule

// File: rtl/ftt_count_core.sv
module ftt_count_core #(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            tick,
  input  logic            edge_in,
  input  logic            wr_cnt,
  input  logic            wr_cap,
  input  logic            wr_lim,
  input  logic [CW/8-1:0] be,
  input  logic [CW-1:0]   wdata,
  output logic [CW-1:0]   cnt_o,
  output logic [CW-1:0]   cap_o,
  output logic [CW-1:0]   lim_o,
  output logic            cap_evt_o,
  output logic            tmo_evt_o
);
  localparam int NLANE = CW / 8;
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] cnt_q, cap_q, lim_q;
  logic [CW-1:0] cnt_m, cap_m, lim_m;
  logic [CW-1:0] cnt_dec;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign cnt_m[l*8 +: 8] = be[l] ? wdata[l*8 +: 8] : cnt_q[l*8 +: 8];
    assign cap_m[l*8 +: 8] = be[l] ? wdata[l*8 +: 8] : cap_q[l*8 +: 8];
    assign lim_m[l*8 +: 8] = be[l] ? wdata[l*8 +: 8] : lim_q[l*8 +: 8];
  end

  assign cnt_dec   = cnt_q - 1'b1;
  assign cap_evt_o = run && edge_in;
  assign tmo_evt_o = run && tick && !cap_evt_o && (cnt_q != '0) && (cnt_dec == lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= TOP;
      cap_q <= TOP;
      lim_q <= '0;
    end else begin
      if (wr_cnt)                      cnt_q <= cnt_m;
      else if (cap_evt_o)              cnt_q <= TOP;
      else if (tick && cnt_q != '0)    cnt_q <= cnt_dec;

      if (wr_cap)                      cap_q <= cap_m;
      else if (cap_evt_o)              cap_q <= cnt_q;

      if (wr_lim)                      lim_q <= lim_m;
    end
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;
  assign lim_o = lim_q;

  // R4
  capture_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_evt_o && !wr_cnt) |=> (cnt_q == TOP));
  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_cnt) |=> $stable(cnt_q));
  // R6
  stop_nocap_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> !cap_evt_o);
  // R9
  floor_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !wr_cnt && !cap_evt_o) |=> (cnt_q == '0));
endmodule

// File: rtl/fan_tach_timer.sv
module fan_tach_timer
  import ftt_pkg::*;
#(
  parameter int CW          = 16,
  parameter int PW          = 8,
  parameter int NPEND       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [CW/8-1:0] bus_be,
  input  logic [CW-1:0]   bus_wdata,
  output logic [CW-1:0]   bus_rdata,
  input  logic            tach_in,
  output logic            irq_o
);
  logic [PW-1:0]    div_q;
  logic             run_q;
  logic [NPEND-1:0] pend_q, mask_q, pend_set, pend_clr;
  logic             rise, tick, cap_evt, tmo_evt;
  logic [CW-1:0]    cnt, cap, lim;
  logic             wr_cnt, wr_cap, wr_lim;

  assign wr_cnt = bus_wr && (bus_addr == OFS_COUNT);
  assign wr_cap = bus_wr && (bus_addr == OFS_CAPT);
  assign wr_lim = bus_wr && (bus_addr == OFS_LIMIT);

  ftt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(tach_in), .rise_o(rise)
  );

  ftt_prescaler #(.PW(PW)) u_presc (
    .clk(clk), .rst(rst), .run(run_q), .restart(cap_evt), .div(div_q), .tick_o(tick)
  );

  ftt_count_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .run(run_q), .tick(tick), .edge_in(rise),
    .wr_cnt(wr_cnt), .wr_cap(wr_cap), .wr_lim(wr_lim),
    .be(bus_be), .wdata(bus_wdata),
    .cnt_o(cnt), .cap_o(cap), .lim_o(lim),
    .cap_evt_o(cap_evt), .tmo_evt_o(tmo_evt)
  );

  always_comb begin
    pend_set = '0;
    pend_set[PEND_CAPT_BIT] = cap_evt;
    pend_set[PEND_TMO_BIT]  = tmo_evt;
    pend_clr = (bus_wr && bus_addr == OFS_ACK && bus_be[0]) ? bus_wdata[NPEND-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      run_q  <= 1'b0;
      mask_q <= '0;
      pend_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (bus_wr && bus_be[0]) begin
        if (bus_addr == OFS_DIV)  div_q  <= bus_wdata[PW-1:0];
        if (bus_addr == OFS_CTRL) run_q  <= bus_wdata[0];
        if (bus_addr == OFS_MASK) mask_q <= bus_wdata[NPEND-1:0];
      end
      pend_q <= (pend_q & ~pend_clr) | pend_set;
      irq_o  <= |(pend_q & mask_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        OFS_COUNT: bus_rdata <= cnt;
        OFS_CAPT:  bus_rdata <= cap;
        OFS_LIMIT: bus_rdata <= lim;
        OFS_DIV:   bus_rdata <= CW'(div_q);
        OFS_CTRL:  bus_rdata <= CW'(run_q);
        OFS_PEND:  bus_rdata <= CW'(pend_q);
        OFS_MASK:  bus_rdata <= CW'(mask_q);
        default:   bus_rdata <= '0;
      endcase
    end
  end

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pend_q) == '0) |-> !irq_o);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> pend_q[PEND_CAPT_BIT]);
  // R5
  tmo_flag_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_evt |=> pend_q[PEND_TMO_BIT]);
endmodule

// File: tb/fan_tach_timer_tb_top.sv
module fan_tach_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata, bus_rdata;
  logic        tach_in;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  fan_tach_timer dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tach_in(tach_in), .irq_o(irq_o)
  );

  localparam int NVEC = 8;
  localparam int VDIV [NVEC] = '{0, 0, 1, 3, 7, 255, 2, 9};
  localparam int VGAP [NVEC] = '{4, 10, 10, 37, 100, 600, 5, 9};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b00;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input int gap_after);
    tach_in = 1'b1;
    repeat (2) @(negedge clk);
    tach_in = 1'b0;
    repeat (gap_after - 2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_be = 0; bus_wdata = 0; tach_in = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {15'd0, irq_o}, 16'h0000);
    rd(4'h0, v); chk("R1 COUNT", v, 16'hFFFF);
    rd(4'h2, v); chk("R1 CAPT",  v, 16'hFFFF);
    rd(4'h4, v); chk("R1 LIMIT", v, 16'h0000);
    rd(4'h6, v); chk("R1 DIV",   v, 16'h0000);
    rd(4'h8, v); chk("R1 CTRL",  v, 16'h0000);
    rd(4'hA, v); chk("R1 PEND",  v, 16'h0000);
    rd(4'hE, v); chk("R1 MASK",  v, 16'h0000);

    // R2 byte lanes
    wr(4'h4, 2'b10, 16'hAB77); rd(4'h4, v); chk("R2 high lane", v, 16'hAB00);
    wr(4'h4, 2'b01, 16'h33CD); rd(4'h4, v); chk("R2 low lane",  v, 16'hABCD);
    wr(4'h4, 2'b11, 16'h0000);

    // R3 R4 table of divider / pulse spacing
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] exp_cap;
      exp_cap = 16'hFFFF - 16'((VGAP[i] - 1) / (VDIV[i] + 1));
      wr(4'h8, 2'b01, 16'h0000);
      wr(4'h6, 2'b01, 16'(VDIV[i]));
      wr(4'h0, 2'b11, 16'hFFFF);
      wr(4'hC, 2'b01, 16'h003F);
      wr(4'h8, 2'b01, 16'h0001);
      pulse(VGAP[i]);
      pulse(8);
      wr(4'h8, 2'b01, 16'h0000);
      rd(4'h2, v); chk("R3 captured interval", v, exp_cap);
      rd(4'hA, v); chk("R4 capture flag", v & 16'h0001, 16'h0001);
      rd(4'h0, v); chk("R4 reload after capture", (v > 16'hFFF0) ? 16'h1 : 16'h0, 16'h0001);
    end

    // R5 stall timeout
    wr(4'h4, 2'b11, 16'hFFEB);
    wr(4'h0, 2'b11, 16'hFFFF);
    wr(4'h6, 2'b01, 16'h0000);
    wr(4'hC, 2'b01, 16'h003F);
    wr(4'h8, 2'b01, 16'h0001);
    repeat (6) @(negedge clk);
    rd(4'hA, v); chk("R5 no early timeout", v, 16'h0000);
    repeat (30) @(negedge clk);
    rd(4'hA, v); chk("R5 timeout flag", v, 16'h0010);
    wr(4'h8, 2'b01, 16'h0000);

    // R8 mask gating
    chk("R8 masked irq", {15'd0, irq_o}, 16'h0000);
    wr(4'hE, 2'b01, 16'h0010);
    @(negedge clk);
    chk("R8 unmasked irq", {15'd0, irq_o}, 16'h0001);

    // R7 selective acknowledge
    wr(4'hC, 2'b01, 16'h0001);
    rd(4'hA, v); chk("R7 other bits kept", v, 16'h0010);
    wr(4'hC, 2'b01, 16'h0010);
    rd(4'hA, v); chk("R7 bit cleared", v, 16'h0000);
    chk("R8 irq drops", {15'd0, irq_o}, 16'h0000);
    wr(4'hE, 2'b01, 16'h0000);

    // R9 floor at zero
    wr(4'h4, 2'b11, 16'h0000);
    wr(4'h0, 2'b11, 16'h0003);
    wr(4'hC, 2'b01, 16'h003F);
    wr(4'h8, 2'b01, 16'h0001);
    repeat (12) @(negedge clk);
    rd(4'h0, v); chk("R9 count stops at zero", v, 16'h0000);
    wr(4'h8, 2'b01, 16'h0000);

    // R6 stopped: hold and ignore tach
    wr(4'h0, 2'b11, 16'h1234);
    wr(4'h2, 2'b11, 16'h0BAD);
    wr(4'hC, 2'b01, 16'h003F);
    pulse(6);
    repeat (4) @(negedge clk);
    rd(4'h0, v); chk("R6 count held", v, 16'h1234);
    rd(4'h2, v); chk("R6 no capture", v, 16'h0BAD);
    rd(4'hA, v); chk("R6 no flag", v, 16'h0000);
    rd(4'hC, v); chk("R2 ACK reads zero", v, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule